// File: doc/BRIEF.md
# Two-Wire Bus Master Bit Sequencer

This block sends one command frame over a two-wire distributed sensor bus through an external transceiver. The transceiver gets two logic lines from it: a frame line and a signal line. While the frame line is low the bus is signalling, and each bit is coded by how long the signal line stays high within a fixed bit cycle. A short high phase means zero and a long one means one. The transceiver senses how much current the slaves draw and reports it as a logic input. The block samples that input at fixed points and packs the return bits into a parallel response word.

A host loads a command word and a bit count, sets the bit-cycle length in clock ticks, and pulses start. The frame line falls, and one full bit cycle of lead-in passes before the first bit. The bits follow most significant first. After the last bit the frame line stays low for a fixed tail and then rises. On that same edge the block pulses done and the response word becomes valid. With no frame in progress the bus idles with both lines high. A disable input puts the bus in its unused high-impedance state instead. The sense input is taken to be synchronous to the clock.

Top module: `bus_bit_seq`

## Requirements
- R1: After reset, and whenever no frame is active and disable_i is low, frame_o and signal_o are both 1. After reset done_o is 0 and resp_o is 0.
- R2: A start is accepted when start_i is high in the idle state. On the next clock edge frame_o and signal_o both go low. They stay low for exactly C clocks, where C is cycle_i sampled at the accepted start. Then signal_o rises to begin the first bit.
- R3: A zero bit drives signal_o high for floor(C/3) clocks. It then drives it low for the rest of the C-clock bit cycle.
- R4: A one bit drives signal_o high for 2*floor(C/3) clocks. It then drives it low for the rest of the C-clock bit cycle.
- R5: Let N be nbits_i. The block sends the bits cmd_i[N-1] down to cmd_i[0], most significant first. It ignores command bits at or above position N.
- R6: After the low phase of the last bit, frame_o stays low for TAIL_TICKS more clocks. Then frame_o and signal_o rise to 1 on the same edge.
- R7: On the edge where signal_o falls in bit k (k >= 1), the block samples sense_i as return bit k-1. The falling edge in bit 0 samples nothing. On the edge where frame_o rises it samples return bit N-1. Return bit 0 lands in resp_o[N-1] and return bit N-1 in resp_o[0]. Bits at or above N read 0.
- R8: done_o is high for exactly one clock, on the edge where frame_o rises. resp_o then holds its value until the next accepted start.
- R9: The block ignores start_i while a frame is active. cmd_i, nbits_i and cycle_i are latched at the accepted start, so later changes to them do not affect the frame.
- R10: The block ignores a start when nbits_i is 0, when nbits_i is greater than DATA_W, or when cycle_i is less than 3.
- R11: While disable_i is high, frame_o is 1 and signal_o is 0 in the same cycle. An active frame is aborted with no done pulse, and starts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disable_i | input | 1 | Forces high-impedance bus state, aborts frame |
| start_i | input | 1 | Start request |
| cmd_i | input | DATA_W | Command word, low nbits_i bits sent |
| nbits_i | input | $clog2(DATA_W+1) | Number of bits in the frame |
| cycle_i | input | CNT_W | Bit-cycle length in clock ticks |
| sense_i | input | 1 | Current-sense return level from transceiver |
| frame_o | output | 1 | Frame line to transceiver |
| signal_o | output | 1 | Signal line to transceiver |
| resp_o | output | DATA_W | Received response word |
| done_o | output | 1 | One-clock frame completion pulse |

## Verification
A wrong phase counter or wrong duty value shows up at the ports within one bit cycle. It appears as a lead-in, high phase or low phase whose length differs by whole clocks from C, floor(C/3) or 2*floor(C/3). A fault in the bit pointer or in the transmit shifter breaks the duty pattern from the first wrong bit onward. A sampling fault changes a single bit of resp_o, and that bit can only be seen at done. For this reason the return bits are chosen so that each sampling point sees a different level from its neighbours. A state that fails to return to idle leaves frame_o low past the expected tail, so the fault appears when frame_o should rise.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BIT,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/bbs_duty.sv
module bbs_duty #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cycle_i,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] t_zero_o,
  output logic [CNT_W-1:0] t_one_o
);
  logic [CNT_W-1:0] third;
  assign third = cycle_i / CNT_W'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o    <= '0;
      t_zero_o <= '0;
      t_one_o  <= '0;
    end else if (load_i) begin
      cyc_o    <= cycle_i;
      t_zero_o <= third;
      t_one_o  <= {third[CNT_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/bbs_tx_shift.sv
module bbs_tx_shift #(
  parameter int DATA_W = 16,
  parameter int BCNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [BCNT_W-1:0] nbits_i,
  output logic              bit_o
);
  localparam logic [BCNT_W-1:0] WB = BCNT_W'(DATA_W);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= cmd_i << (WB - nbits_i); // left-justify: first bit at MSB
    else if (adv_i)  sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign bit_o = sh_q[DATA_W-1];
endmodule

// File: rtl/bbs_rx_shift.sv
module bbs_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              sense_i,
  output logic [DATA_W-1:0] resp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     resp_o <= '0;
    else if (clr_i)  resp_o <= '0;
    else if (cap_i)  resp_o <= {resp_o[DATA_W-2:0], sense_i};
  end
endmodule

// File: rtl/bus_bit_seq.sv
module bus_bit_seq
  import bbs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int TAIL_TICKS = 50,
  localparam int BCNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disable_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [BCNT_W-1:0] nbits_i,
  input  logic [CNT_W-1:0]  cycle_i,
  input  logic              sense_i,
  output logic              frame_o,
  output logic              signal_o,
  output logic [DATA_W-1:0] resp_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0]  TAIL_M1 = CNT_W'(TAIL_TICKS - 1);
  localparam logic [BCNT_W-1:0] MAXB    = BCNT_W'(DATA_W);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BCNT_W-1:0] idx_q, nbits_q;
  logic              frame_q, sig_q, done_q;

  logic [CNT_W-1:0]  cyc, t_zero, t_one, hi_len;
  logic              cur_bit, accept, last_bit, hi_end, cyc_end, tail_end, cap, adv;

  assign accept   = (state_q == ST_IDLE) && start_i && !disable_i &&
                    (nbits_i != '0) && (nbits_i <= MAXB) && (cycle_i >= CNT_W'(3));
  assign hi_len   = cur_bit ? t_one : t_zero;
  assign hi_end   = (cnt_q == hi_len - 1'b1);
  assign cyc_end  = (cnt_q == cyc - 1'b1);
  assign tail_end = (cnt_q == TAIL_M1);
  assign last_bit = (idx_q == nbits_q - 1'b1);
  assign cap      = !disable_i &&
                    (((state_q == ST_BIT) && hi_end && (idx_q != '0)) ||
                     ((state_q == ST_TAIL) && tail_end));
  assign adv      = !disable_i && (state_q == ST_BIT) && cyc_end && !last_bit;

  bbs_duty #(.CNT_W(CNT_W)) i_duty (
    .clk_i, .rst_ni, .load_i(accept), .cycle_i,
    .cyc_o(cyc), .t_zero_o(t_zero), .t_one_o(t_one)
  );

  bbs_tx_shift #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) i_tx (
    .clk_i, .rst_ni, .load_i(accept), .adv_i(adv),
    .cmd_i, .nbits_i, .bit_o(cur_bit)
  );

  bbs_rx_shift #(.DATA_W(DATA_W)) i_rx (
    .clk_i, .rst_ni, .clr_i(accept), .cap_i(cap),
    .sense_i, .resp_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      nbits_q <= '0;
      frame_q <= 1'b1;
      sig_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (disable_i) begin
        state_q <= ST_IDLE;
        frame_q <= 1'b1;
        sig_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept) begin
            state_q <= ST_LEAD;
            cnt_q   <= '0;
            nbits_q <= nbits_i;
            frame_q <= 1'b0;
            sig_q   <= 1'b0;
          end
          ST_LEAD: if (cyc_end) begin
            state_q <= ST_BIT;
            cnt_q   <= '0;
            idx_q   <= '0;
            sig_q   <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          ST_BIT: begin
            if (hi_end) sig_q <= 1'b0;
            if (cyc_end) begin
              cnt_q <= '0;
              if (last_bit) state_q <= ST_TAIL;
              else begin
                idx_q <= idx_q + 1'b1;
                sig_q <= 1'b1;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_TAIL: if (tail_end) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b1;
            sig_q   <= 1'b1;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign frame_o  = frame_q | disable_i;
  assign signal_o = sig_q & ~disable_i;
  assign done_o   = done_q;
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              disable_i,
  input logic              start_i,
  input logic              frame_o,
  input logic              signal_o,
  input logic [DATA_W-1:0] resp_o,
  input logic              done_o
);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !disable_i) |-> signal_o);

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(frame_o));

  p_hiz_only_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && !signal_o) |-> disable_i);

  p_abort_no_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !done_o);

  p_resp_change_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(resp_o) |-> ($past(start_i) || $fell(signal_o) || $rose(frame_o)));
endmodule

bind bus_bit_seq bbs_checker #(.DATA_W(DATA_W)) i_bbs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .disable_i(disable_i), .start_i(start_i),
  .frame_o(frame_o), .signal_o(signal_o), .resp_o(resp_o), .done_o(done_o)
);

// File: tb/test_bus_bit_seq.sv
`timescale 1ns/1ps
module test_bus_bit_seq;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int TT = 50;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          disable_i = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] cmd_i = '0;
  logic [4:0]    nbits_i = '0;
  logic [CW-1:0] cycle_i = '0;
  logic          sense_i = 1'b0;
  logic          frame_o, signal_o, done_o;
  logic [DW-1:0] resp_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  bus_bit_seq #(.DATA_W(DW), .CNT_W(CW), .TAIL_TICKS(TT)) i_bus_bit_seq (
    .clk_i, .rst_ni, .disable_i, .start_i, .cmd_i, .nbits_i, .cycle_i,
    .sense_i, .frame_o, .signal_o, .resp_o, .done_o
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Full frame: measures every phase, drives return bits, checks response.
  task automatic run_frame(input logic [DW-1:0] cmd, input int n, input int cyc,
                           input logic [DW-1:0] r, input bit poke);
    int lead, h, l, hi;
    bit bv;
    @(negedge clk_i);
    cmd_i = cmd; nbits_i = 5'(n); cycle_i = CW'(cyc); start_i = 1'b1; sense_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; cmd_i = ~cmd; cycle_i = CW'(cyc + 3); nbits_i = 5'(n == 1 ? 2 : n - 1);
    chk("R2 frame falls", !frame_o && !signal_o, frame_o, 0);
    lead = 0;
    while (!frame_o && !signal_o && lead < 5000) begin
      lead++;
      @(negedge clk_i);
    end
    chk("R2 lead length", lead == cyc, lead, cyc);
    for (int j = 0; j < n; j++) begin
      bv = cmd[n-1-j];
      hi = bv ? 2 * (cyc / 3) : cyc / 3;
      h = 0;
      while (signal_o && !frame_o && h < 5000) begin
        sense_i = (j >= 1) ? r[n-j] : ~r[n-1];
        start_i = (poke && j == 0 && h == 0);
        h++;
        @(negedge clk_i);
      end
      start_i = 1'b0;
      if (bv) chk("R4 R5 one high", h == hi, h, hi);
      else    chk("R3 R5 zero high", h == hi, h, hi);
      l = 0;
      while (!signal_o && !frame_o && l < 5000) begin
        sense_i = (j == n - 1) ? r[0] : ~r[n-1-j];
        l++;
        @(negedge clk_i);
      end
      if (j == n - 1) chk("R6 last low plus tail", l == cyc - hi + TT, l, cyc - hi + TT);
      else            chk("R3 R4 low phase", l == cyc - hi, l, cyc - hi);
    end
    chk("R6 frame and signal rise", frame_o && signal_o, {frame_o, signal_o}, 3);
    chk("R8 done at rise", done_o, done_o, 1);
    chk("R7 response", resp_o == r, resp_o, r);
    @(negedge clk_i);
    chk("R8 done one clock", !done_o, done_o, 0);
    if (poke) chk("R9 restart ignored", frame_o, frame_o, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset frame/signal", frame_o && signal_o, {frame_o, signal_o}, 3);
    chk("R1 reset done", !done_o, done_o, 0);
    chk("R1 reset resp", resp_o == '0, resp_o, 0);
  endtask

  task automatic t_hold(input logic [DW-1:0] r);
    repeat (30) @(negedge clk_i);
    chk("R8 resp held", resp_o == r, resp_o, r);
    chk("R1 idle between frames", frame_o && signal_o, {frame_o, signal_o}, 3);
  endtask

  task automatic t_bad_start(input int n, input int cyc, input string tag);
    bit moved = 0;
    @(negedge clk_i);
    nbits_i = 5'(n); cycle_i = CW'(cyc); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (!frame_o || done_o) moved = 1;
      @(negedge clk_i);
    end
    chk(tag, !moved, moved, 0);
  endtask

  task automatic t_disable();
    bit bad = 0;
    @(negedge clk_i);
    disable_i = 1'b1;
    #1;
    chk("R11 hiz when idle", frame_o && !signal_o, {frame_o, signal_o}, 2);
    cmd_i = 16'h00FF; nbits_i = 5'd8; cycle_i = 16'd12; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (5) begin
      if (!frame_o || signal_o) bad = 1;
      @(negedge clk_i);
    end
    chk("R11 start blocked", !bad, bad, 0);
    disable_i = 1'b0;
    @(negedge clk_i);
    chk("R11 idle after release", frame_o && signal_o, {frame_o, signal_o}, 3);
    // abort mid-frame
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk("R11 frame running", !frame_o, frame_o, 0);
    disable_i = 1'b1;
    #1;
    chk("R11 abort hiz", frame_o && !signal_o, {frame_o, signal_o}, 2);
    bad = 0;
    repeat (3) begin
      @(negedge clk_i);
      if (done_o) bad = 1;
    end
    disable_i = 1'b0;
    repeat (200) begin
      @(negedge clk_i);
      if (done_o || !frame_o || !signal_o) bad = 1;
    end
    chk("R11 aborted no done", !bad, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    run_frame(16'h00A5, 8, 12, 16'h003C, 1'b0);
    t_hold(16'h003C);
    run_frame(16'h8001, 16, 30, 16'hF00F, 1'b0);
    run_frame(16'hFFFF, 1, 7, 16'h0001, 1'b0);
    run_frame(16'h0006, 4, 330, 16'h0009, 1'b1);
    run_frame(16'hFFFA, 3, 13, 16'h0005, 1'b1);
    t_bad_start(0, 12, "R10 zero bits ignored");
    t_bad_start(17, 12, "R10 too many bits ignored");
    t_bad_start(4, 2, "R10 short cycle ignored");
    chk("R10 resp kept", resp_o == 16'h0005, resp_o, 5);
    t_disable();
    run_frame(16'h0002, 2, 3, 16'h0002, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000 && !finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule